// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This controller sits between a simple request port and a classical asynchronous DRAM. The request port carries an address, a read/write flag, one write data bit and a valid/ready handshake. The DRAM side has active-low row and column strobes, an active-low write enable, a shared address bus and a data bit. The data bit is split into input, output and output-enable, so a pad can build the bidirectional pin from them.

Each request address is split into a row half (upper bits) and a column half (lower bits). Both halves go out on the same address pins, row first. After an access the row stays open. A later request to the same row only pulses the column strobe. A request to a different row, an idle timeout or a due refresh closes the row first. All strobe timing is counted in clock cycles set by parameters.

A refresh timer raises a pending flag at a fixed interval. The flag is served at the next gap between accesses, in one of two styles picked by `ref_mode_i`:
- Row-strobe-only refresh, which uses an internal row counter.
- Column-before-row refresh, which uses the counter inside the device.

Top module: `dram_ctrl`

## Requirements
- R1: The request address is split into row = `req_addr_i[ROW_W+COL_W-1:COL_W]` and column = `req_addr_i[COL_W-1:0]`. `dram_addr_o` holds the row in the cycle before and the cycle of the row strobe fall. It holds the column in the cycle before and the cycle of the column strobe fall during an access.
- R2: A read returns the bit stored at its address on `rsp_rdata_o`. `rsp_valid_o` pulses for exactly one cycle: the first cycle after the column strobe rises. Writes give no response.
- R3: `dram_dq_oe_o` is high only while `dram_cas_no` and `dram_we_no` are both low. A write stores `req_wdata_i` at its address.
- R4: A request to the row that is already open is served with a column strobe pulse only. The row strobe stays low, so no new row strobe fall occurs.
- R5: A request to a different row than the open one first raises the row strobe. It then opens the new row and returns correct data.
- R6: The row strobe stays high for at least T_RP cycles before every fall.
- R7: The column strobe falls no sooner than T_RCD cycles after the row strobe falls. Every column strobe pulse lasts at least T_CAS cycles.
- R8: An open row with no request for IDLE_TO cycles is closed (row strobe high).
- R9: A refresh becomes pending every REF_INT cycles. It is served after any open row has been closed, and no request is accepted while it is pending.
- R10: With `ref_mode_i`=0, a refresh pulses the row strobe low and keeps the column strobe high. The address comes from a row counter that increments by one (mod 2^ROW_W) per refresh.
- R11: With `ref_mode_i`=1, a refresh drops the column strobe while the row strobe is high, then pulses the row strobe low. Both strobes then return high.
- R12: After reset, both strobes and write enable are high, `dram_dq_oe_o`, `rsp_valid_o` and `req_ready_o` are low with no request present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_mode_i | input | 1 | Refresh style: 0 row-strobe-only, 1 column-before-row |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Request address, row in upper bits |
| req_wdata_i | input | 1 | Write data bit |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 1 | Read data bit |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| dram_dq_i | input | 1 | Data from the DRAM pin |
| dram_dq_o | output | 1 | Data to the DRAM pin |
| dram_dq_oe_o | output | 1 | Output driver enable for the data pin |

## Verification
The hardest situations to reach from the ports are the fixed sequences: a page hit followed by a row miss, and an open row timing out. The refresh timer runs freely, so a refresh could land in the middle and change the strobe pattern. The stimulus first waits until the bench's strobe monitor sees a refresh complete. The directed sequence then runs well inside one refresh interval, so the counted row strobe falls and the timeout cycle can be predicted exactly. The bench also includes a small DRAM model that latches row and column on the strobe edges. Read-back through this model shows that the row/column split and the page-mode column changes address the right bits.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCD,
    ST_CAS,
    ST_OPEN,
    ST_ROR,
    ST_CBR_C,
    ST_CBR_R
  } dram_st_e;

  typedef enum logic [2:0] {
    SEL_IN_ROW,
    SEL_Q_ROW,
    SEL_IN_COL,
    SEL_Q_COL,
    SEL_REF
  } addr_sel_e;

endpackage

// File: rtl/dram_rp_timer.sv
module dram_rp_timer #(
  parameter int T_RP = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ras_n_i,
  output logic rp_ok_o
);
  localparam int W = $clog2(T_RP + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!ras_n_i) cnt_q <= '0;
    else if (cnt_q != W'(T_RP)) cnt_q <= cnt_q + 1'b1;
  end

  // current cycle counts too, hence T_RP-1
  assign rp_ok_o = ras_n_i && (cnt_q >= W'(T_RP - 1));
endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int INTERVAL = 512,
  parameter int ROW_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             row_inc_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0]    tmr_q;
  logic             pend_q;
  logic [ROW_W-1:0] row_q;
  logic             wrap;

  assign wrap = (tmr_q == TW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      tmr_q <= wrap ? '0 : tmr_q + 1'b1;
      if (done_i) pend_q <= 1'b0;
      if (wrap) pend_q <= 1'b1;
      if (done_i && row_inc_i) row_q <= row_q + 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign row_o  = row_q;
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int AW    = ROW_W + COL_W,
  parameter int DA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic [AW-1:0]    in_addr_i,
  input  logic [AW-1:0]    q_addr_i,
  input  logic [ROW_W-1:0] ref_row_i,
  input  addr_sel_e        sel_i,
  output logic [DA_W-1:0]  dram_addr_o
);
  logic [DA_W-1:0] in_row, q_row, in_col, q_col, ref_row;

  assign in_row  = DA_W'(in_addr_i[AW-1:COL_W]);
  assign q_row   = DA_W'(q_addr_i[AW-1:COL_W]);
  assign in_col  = DA_W'(in_addr_i[COL_W-1:0]);
  assign q_col   = DA_W'(q_addr_i[COL_W-1:0]);
  assign ref_row = DA_W'(ref_row_i);

  always_comb begin
    unique case (sel_i)
      SEL_IN_ROW: dram_addr_o = in_row;
      SEL_Q_ROW:  dram_addr_o = q_row;
      SEL_IN_COL: dram_addr_o = in_col;
      SEL_Q_COL:  dram_addr_o = q_col;
      SEL_REF:    dram_addr_o = ref_row;
      default:    dram_addr_o = q_row;
    endcase
  end
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W   = 4,
  parameter int COL_W   = 4,
  parameter int T_RP    = 3,
  parameter int T_RCD   = 2,  // must be >= 2: last cycle previews the column
  parameter int T_CAS   = 2,
  parameter int T_RAS   = 4,
  parameter int IDLE_TO = 8,
  parameter int REF_INT = 512,
  parameter int AW      = ROW_W + COL_W,
  parameter int DA_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_mode_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_we_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic            req_wdata_i,
  output logic            rsp_valid_o,
  output logic            rsp_rdata_o,
  output logic            dram_ras_no,
  output logic            dram_cas_no,
  output logic            dram_we_no,
  output logic [DA_W-1:0] dram_addr_o,
  input  logic            dram_dq_i,
  output logic            dram_dq_o,
  output logic            dram_dq_oe_o
);
  localparam int TMAX = (T_RCD > T_CAS) ? ((T_RCD > T_RAS) ? T_RCD : T_RAS)
                                        : ((T_CAS > T_RAS) ? T_CAS : T_RAS);
  localparam int CW = $clog2(TMAX + 1);
  localparam int IW = $clog2(IDLE_TO + 1);

  dram_st_e         st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IW-1:0]    idle_q;
  logic [AW-1:0]    addr_q;
  logic             we_q, wd_q, rd_q, rsp_q;
  logic             lat, cap, ref_done, ready;
  logic             rp_ok, ref_pend, hit, idle_exp;
  logic [ROW_W-1:0] ref_row;
  addr_sel_e        sel;

  dram_rp_timer #(.T_RP(T_RP)) u_rp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ras_n_i(dram_ras_no),
    .rp_ok_o(rp_ok)
  );

  dram_ref_timer #(.INTERVAL(REF_INT), .ROW_W(ROW_W)) u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (ref_done),
    .row_inc_i(st_q == ST_ROR),
    .pend_o   (ref_pend),
    .row_o    (ref_row)
  );

  dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .AW(AW), .DA_W(DA_W)) u_mux (
    .in_addr_i  (req_addr_i),
    .q_addr_i   (addr_q),
    .ref_row_i  (ref_row),
    .sel_i      (sel),
    .dram_addr_o(dram_addr_o)
  );

  assign hit      = (req_addr_i[AW-1:COL_W] == addr_q[AW-1:COL_W]);
  assign idle_exp = (idle_q >= IW'(IDLE_TO - 1));

  always_comb begin
    st_d     = st_q;
    cnt_d    = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    lat      = 1'b0;
    cap      = 1'b0;
    ref_done = 1'b0;
    ready    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend) begin
          if (rp_ok) begin
            if (ref_mode_i) begin
              st_d  = ST_CBR_C;
              cnt_d = '0;
            end else begin
              st_d  = ST_ROR;
              cnt_d = CW'(T_RAS - 1);
            end
          end
        end else if (req_valid_i && rp_ok) begin
          ready = 1'b1;
          lat   = 1'b1;
          st_d  = ST_RCD;
          cnt_d = CW'(T_RCD - 1);
        end
      end
      ST_RCD: begin
        if (cnt_q == '0) begin
          st_d  = ST_CAS;
          cnt_d = CW'(T_CAS - 1);
        end
      end
      ST_CAS: begin
        if (cnt_q == '0) begin
          cap  = !we_q;
          st_d = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (ref_pend || idle_exp) begin
          st_d = ST_IDLE;
        end else if (req_valid_i) begin
          if (hit) begin
            ready = 1'b1;
            lat   = 1'b1;
            st_d  = ST_CAS;
            cnt_d = CW'(T_CAS - 1);
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_ROR: begin
        if (cnt_q == '0) begin
          ref_done = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      ST_CBR_C: begin
        st_d  = ST_CBR_R;
        cnt_d = CW'(T_RAS - 1);
      end
      ST_CBR_R: begin
        if (cnt_q == '0) begin
          ref_done = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // address shown one cycle ahead of each strobe edge
  always_comb begin
    unique case (st_q)
      ST_IDLE:  sel = (ref_pend && !ref_mode_i) ? SEL_REF : SEL_IN_ROW;
      ST_RCD:   sel = (cnt_q == '0) ? SEL_Q_COL : SEL_Q_ROW;
      ST_CAS:   sel = SEL_Q_COL;
      ST_OPEN:  sel = SEL_IN_COL;
      ST_ROR:   sel = SEL_REF;
      default:  sel = SEL_Q_ROW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idle_q <= '0;
      addr_q <= '0;
      we_q   <= 1'b0;
      wd_q   <= 1'b0;
      rd_q   <= 1'b0;
      rsp_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idle_q <= (st_q == ST_OPEN && st_d == ST_OPEN) ? idle_q + 1'b1 : '0;
      rsp_q  <= cap;
      if (cap) rd_q <= dram_dq_i;
      if (lat) begin
        addr_q <= req_addr_i;
        we_q   <= req_we_i;
        wd_q   <= req_wdata_i;
      end
    end
  end

  assign dram_ras_no  = !(st_q inside {ST_RCD, ST_CAS, ST_OPEN, ST_ROR, ST_CBR_R});
  assign dram_cas_no  = !(st_q inside {ST_CAS, ST_CBR_C, ST_CBR_R});
  assign dram_we_no   = !(st_q == ST_CAS && we_q);
  assign dram_dq_oe_o = (st_q == ST_CAS) && we_q;
  assign dram_dq_o    = wd_q;
  assign req_ready_o  = ready;
  assign rsp_valid_o  = rsp_q;
  assign rsp_rdata_o  = rd_q;
endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk #(
  parameter int T_RP  = 3,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int DA_W  = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            rsp_valid_o,
  input logic            dram_ras_no,
  input logic            dram_cas_no,
  input logic            dram_we_no,
  input logic [DA_W-1:0] dram_addr_o,
  input logic            dram_dq_oe_o
);
  logic [15:0] hi_q, lo_q, cl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
      cl_q <= '0;
    end else begin
      hi_q <= dram_ras_no ? ((hi_q != '1) ? hi_q + 1'b1 : hi_q) : '0;
      lo_q <= !dram_ras_no ? ((lo_q != '1) ? lo_q + 1'b1 : lo_q) : '0;
      cl_q <= !dram_cas_no ? ((cl_q != '1) ? cl_q + 1'b1 : cl_q) : '0;
    end
  end

  // R6
  rp_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> hi_q >= 16'(T_RP));
  // R7
  rcd_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no) && !dram_ras_no) |-> lo_q >= 16'(T_RCD));
  // R7
  cas_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_cas_no) |-> cl_q >= 16'(T_CAS));
  // R3
  oe_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_dq_oe_o |-> (!dram_cas_no && !dram_we_no));
  // R1
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> $stable(dram_addr_o));
  // R1
  col_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no) && !dram_ras_no) |-> $stable(dram_addr_o));
  // R2
  rsp_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $rose(dram_cas_no));
  // R4
  page_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !dram_ras_no) |=> !dram_ras_no);
  // R11
  cbr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_ras_no) && !dram_cas_no) |-> $past(!dram_cas_no));
endmodule

bind dram_ctrl dram_ctrl_chk #(
  .T_RP (T_RP),
  .T_RCD(T_RCD),
  .T_CAS(T_CAS),
  .DA_W (DA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .dram_ras_no (dram_ras_no),
  .dram_cas_no (dram_cas_no),
  .dram_we_no  (dram_we_no),
  .dram_addr_o (dram_addr_o),
  .dram_dq_oe_o(dram_dq_oe_o)
);

// File: tb/tb_dram_ctrl.sv
`timescale 1ns/1ps
module tb_dram_ctrl;
  localparam int T_RP = 3, T_RCD = 2, T_CAS = 2, IDLE_TO = 8, REF_INT = 120;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_mode = 1'b0, req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
  logic [7:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_rdata, ras_n, cas_n, we_n, dq_o, dq_oe, dq_i;
  logic [3:0] dram_addr;

  always #10 clk = ~clk;

  dram_ctrl #(.ROW_W(4), .COL_W(4), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
              .T_RAS(4), .IDLE_TO(IDLE_TO), .REF_INT(REF_INT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_mode_i(ref_mode),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n),
    .dram_addr_o(dram_addr), .dram_dq_i(dq_i), .dram_dq_o(dq_o),
    .dram_dq_oe_o(dq_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // DRAM model and strobe monitor
  logic [255:0] mem = '0;
  logic [3:0] m_row = '0, m_col = '0, cur_row = '0, last_ro = '0;
  logic pras = 1'b1, pcas = 1'b1, saw_cas = 1'b0, in_cbr = 1'b0, have_ro = 1'b0;
  int hi = 0, lo = 0, cl = 0, t_viol = 0, oe_viol = 0, seq_err = 0;
  int opens = 0, ro_n = 0, cbr_n = 0;

  assign dq_i = (!cas_n && !ras_n && we_n) ? mem[{m_row, m_col}] : 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n && pras) begin
        if (hi < T_RP) t_viol++;
        if (!cas_n) begin cbr_n++; in_cbr = 1'b1; end
        else begin opens++; m_row = dram_addr; cur_row = dram_addr; saw_cas = 1'b0; in_cbr = 1'b0; end
      end
      if (!cas_n && pcas && !ras_n) begin
        if (lo < T_RCD) t_viol++;
        m_col = dram_addr; saw_cas = 1'b1;
      end
      if (cas_n && !pcas && cl < T_CAS) t_viol++;
      if (ras_n && !pras && !in_cbr && !saw_cas) begin
        ro_n++;
        if (have_ro && cur_row != last_ro + 4'd1) seq_err++;
        last_ro = cur_row; have_ro = 1'b1;
      end
      if (dq_oe && (cas_n || we_n)) oe_viol++;
      if (dq_oe && !cas_n && !ras_n) mem[{m_row, m_col}] = dq_o;
      hi = ras_n ? hi + 1 : 0;
      lo = !ras_n ? lo + 1 : 0;
      cl = !cas_n ? cl + 1 : 0;
      pras = ras_n; pcas = cas_n;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [7:0] a, input logic d,
                        output logic rd, output logic rsp_cas);
    int t;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    t = 0; #1;
    while (!req_ready && t < 300) begin @(negedge clk); #1; t++; end
    @(negedge clk);
    req_valid = 1'b0;
    rd = 1'b0; rsp_cas = 1'b0;
    if (!we) begin
      t = 0;
      while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
      rd = rsp_rdata; rsp_cas = cas_n;
    end
  endtask

  task automatic wait_refresh();
    int s, t;
    s = ro_n + cbr_n; t = 0;
    while (ro_n + cbr_n == s && t < 1000) begin @(negedge clk); t++; end
  endtask

  // we, addr, wdata, expected read
  localparam logic [10:0] VEC [0:10] = '{
    {1'b1, 8'h35, 1'b1, 1'b0}, {1'b1, 8'h36, 1'b0, 1'b0},
    {1'b1, 8'h3A, 1'b1, 1'b0}, {1'b1, 8'h70, 1'b1, 1'b0},
    {1'b0, 8'h35, 1'b0, 1'b1}, {1'b0, 8'h36, 1'b0, 1'b0},
    {1'b0, 8'h70, 1'b0, 1'b1}, {1'b0, 8'h3A, 1'b0, 1'b1},
    {1'b0, 8'hC2, 1'b0, 1'b0}, {1'b1, 8'h35, 1'b0, 1'b0},
    {1'b0, 8'h35, 1'b0, 1'b0}
  };

  initial begin
    logic rd, rc;
    int o0, r0, c0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 ras_n", ras_n, 1); check("R12 cas_n", cas_n, 1);
    check("R12 we_n", we_n, 1); check("R12 dq_oe", dq_oe, 0);
    check("R12 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 ready idle", req_ready, 0);

    // R1 R2 R3 vector walk through the DRAM model
    for (int i = 0; i < 11; i++) begin
      do_req(VEC[i][10], VEC[i][9:2], VEC[i][1], rd, rc);
      if (!VEC[i][10]) begin
        check($sformatf("R2 R1 R3 read vec%0d", i), rd, VEC[i][0]);
        check("R2 rsp after cas rise", rc, 1);
      end
    end

    // R4 R5 page hit then row miss, inside one refresh interval
    wait_refresh();
    o0 = opens;
    do_req(1'b0, 8'h35, 1'b0, rd, rc);
    do_req(1'b0, 8'h3A, 1'b0, rd, rc);
    check("R4 page hit data", rd, 1);
    check("R4 single row open", opens - o0, 1);
    do_req(1'b0, 8'h70, 1'b0, rd, rc);
    check("R5 miss data", rd, 1);
    check("R5 new row open", opens - o0, 2);

    // R8 idle timeout
    wait_refresh();
    do_req(1'b0, 8'h36, 1'b0, rd, rc);
    repeat (3) @(negedge clk);
    check("R8 still open", ras_n, 0);
    repeat (7) @(negedge clk);
    check("R8 closed after timeout", ras_n, 1);

    // R9 R10 row-strobe-only refresh
    r0 = ro_n; c0 = cbr_n;
    repeat (3 * REF_INT + 20) @(negedge clk);
    check("R9 refresh rate", (ro_n - r0) >= 3, 1);
    check("R10 no cbr in mode0", cbr_n - c0, 0);
    check("R10 row counter sequence", seq_err, 0);

    // R11 column-before-row refresh
    ref_mode = 1'b1;
    wait_refresh();
    r0 = ro_n; c0 = cbr_n;
    repeat (3 * REF_INT + 20) @(negedge clk);
    check("R11 cbr count", (cbr_n - c0) >= 3, 1);
    check("R11 no ras-only in mode1", ro_n - r0, 0);
    do_req(1'b0, 8'h3A, 1'b0, rd, rc);
    check("R9 access after refreshes", rd, 1);

    check("R6 R7 strobe timing", t_viol, 0);
    check("R3 driver window", oe_viol, 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule